// File: doc/BRIEF.md
# Zero-Cycle Branch Target Address Cache

This block sits beside an instruction fetch stage. In the same cycle that the fetch unit presents a fetch address, the block searches a small fully associative table of recently resolved branches. On a hit it supplies the stored target, and the fetch unit uses that target as the next fetch address, so no idle cycle is spent between a branch and its target. On a miss it supplies the sequential successor (fetch address plus one instruction of 4 bytes).

With zero-cycle keying enabled, an entry is tagged with the fetch address of the instruction just before the branch (branch address minus 4). The redirect then happens one fetch earlier, and the first target instruction follows the last sequential instruction before the branch directly. Branch resolution writes the table through an update port that carries the branch address, its target and its direction. A parameter selects whether every resolved branch is allocated or only taken ones. The taken-only setting works as an implicit taken prediction. A flush input empties the table in one cycle.

Top module: `zc_btac`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, every lookup misses. An update presented in the same cycle as `flush` is dropped.
- R2: On a miss, `hit` is 0, `pred_target` is 0 and `next_fetch` equals `fetch_addr` + 4.
- R3: On a hit, `hit` is 1 and both `pred_target` and `next_fetch` equal the stored target, in the same cycle that `fetch_addr` is presented.
- R4: With `ZERO_CYCLE`=1, an update for branch address B is stored under tag B − 4, and a lookup at B itself misses. With `ZERO_CYCLE`=0 the tag is B, and a lookup at B − 4 misses.
- R5: When a lookup and an update to the same tag occur in the same cycle, the lookup returns the table contents from before the update. The new contents are visible from the next cycle.
- R6: With `TAKEN_ONLY`=1, a not-taken update whose tag misses allocates nothing, and a not-taken update whose tag hits invalidates that entry.
- R7: With `TAKEN_ONLY`=0, every update allocates or refreshes an entry regardless of `upd_taken`, and a hit updates the stored target.
- R8: An update whose tag matches a valid entry overwrites that entry's target in place. No two valid entries ever share a tag.
- R9: A new entry goes into the lowest-index invalid slot. When no slot is free, the victim is chosen by a round-robin pointer. The pointer is 0 after reset, advances by one (wrapping) only on a replacement, and is not changed by a flush.
- R10: `ENTRIES` distinct branches can be held at the same time, and all of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| fetch_addr | input | ADDR_W | Current fetch address to look up |
| hit | output | 1 | Lookup found a valid entry |
| pred_target | output | ADDR_W | Stored target on hit, 0 on miss |
| next_fetch | output | ADDR_W | Address to fetch in the next cycle |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_branch | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Resolved branch target |
| upd_taken | input | 1 | Resolved branch direction |

## Verification
Several checks run on every clock: at most one entry matches a lookup or an update tag, the number of valid entries grows by at most one per cycle, the table is empty after a flush, and in taken-only mode a not-taken update never grows the table. The bench alone can show the values that go with these events. It checks which target comes back, the effect of the minus-4 keying, the old-versus-new result when a lookup and an update collide, and the exact order of round-robin victims after free slots are mixed with replacements. It sweeps full tables of 32 and 256 entries.

// File: rtl/zc_btac.sv
module zc_btac #(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 32,
  parameter int INSN_BYTES = 4,
  parameter bit ZERO_CYCLE = 1'b1,
  parameter bit TAKEN_ONLY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] pred_target,
  output logic [ADDR_W-1:0] next_fetch,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_branch,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] look_match, upd_match;
  logic [ADDR_W-1:0]  upd_tag;
  logic [IDX_W-1:0]   upd_idx, free_idx, wr_idx;
  logic               upd_hit, free_any, keep, wr_en, do_alloc, do_kill;

  assign upd_tag = ZERO_CYCLE ? upd_branch - STEP : upd_branch;
  assign keep    = upd_taken || !TAKEN_ONLY;

  always_comb begin
    pred_target = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      look_match[i] = valid_q[i] && (tag_q[i] == fetch_addr);
      upd_match[i]  = valid_q[i] && (tag_q[i] == upd_tag);
      if (look_match[i]) pred_target = pred_target | tgt_q[i];
    end
  end

  assign hit        = |look_match;
  assign next_fetch = hit ? pred_target : fetch_addr + STEP;

  always_comb begin
    upd_idx  = '0;
    free_idx = '0;
    free_any = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (upd_match[i]) upd_idx = IDX_W'(i);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
  end

  assign upd_hit  = |upd_match;
  assign do_alloc = upd_valid && !flush && !upd_hit && keep;
  assign do_kill  = upd_valid && !flush && upd_hit && !keep;
  assign wr_en    = do_alloc || (upd_valid && !flush && upd_hit && keep);
  assign wr_idx   = upd_hit ? upd_idx : (free_any ? free_idx : rr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      if (do_alloc) begin
        valid_q[wr_idx] <= 1'b1;
        if (!free_any) rr_q <= rr_q + 1'b1;
      end
      if (do_kill) valid_q[upd_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= upd_tag;
      tgt_q[wr_idx] <= upd_target;
    end
  end

  AST_ONE_LOOK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match)); // R8
  AST_ONE_UPD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_match)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0) && !hit); // R1
  AST_GROW_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rst_n) |-> ($countones(valid_q) <= $past($countones(valid_q)) + 1)); // R8

  if (TAKEN_ONLY) begin : g_taken_only_chk
    AST_NOT_TAKEN_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |=> ($countones(valid_q) <= $past($countones(valid_q)))); // R6
  end

endmodule

// File: tb/test_zc_btac.sv
module test_zc_btac;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic a_flush = 0, a_uv = 0, a_tk = 0, a_hit;
  logic [31:0] a_fa = 0, a_br = 0, a_tg = 0, a_pt, a_nf;
  logic b_flush = 0, b_uv = 0, b_tk = 0, b_hit;
  logic [31:0] b_fa = 0, b_br = 0, b_tg = 0, b_pt, b_nf;

  zc_btac #(.ENTRIES(32), .ZERO_CYCLE(1'b1), .TAKEN_ONLY(1'b1)) i_zc_btac (
    .clk(clk), .rst_n(rst_n), .flush(a_flush), .fetch_addr(a_fa), .hit(a_hit),
    .pred_target(a_pt), .next_fetch(a_nf), .upd_valid(a_uv), .upd_branch(a_br),
    .upd_target(a_tg), .upd_taken(a_tk));

  zc_btac #(.ENTRIES(256), .ZERO_CYCLE(1'b0), .TAKEN_ONLY(1'b0)) i_zc_btac_b (
    .clk(clk), .rst_n(rst_n), .flush(b_flush), .fetch_addr(b_fa), .hit(b_hit),
    .pred_target(b_pt), .next_fetch(b_nf), .upd_valid(b_uv), .upd_branch(b_br),
    .upd_target(b_tg), .upd_taken(b_tk));

  int checks = 0, fails = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look_a(logic [31:0] addr, logic eh, logic [31:0] et, string req);
    @(negedge clk); a_fa = addr; #1;
    chk(req, {31'd0, a_hit}, {31'd0, eh});
    chk(req, a_nf, eh ? et : addr + 4);
    chk(req, a_pt, eh ? et : 32'd0);
  endtask

  task automatic look_b(logic [31:0] addr, logic eh, logic [31:0] et, string req);
    @(negedge clk); b_fa = addr; #1;
    chk(req, {31'd0, b_hit}, {31'd0, eh});
    chk(req, b_nf, eh ? et : addr + 4);
  endtask

  task automatic upd_a(logic [31:0] br, logic [31:0] tg, logic tk);
    @(negedge clk); a_uv = 1; a_br = br; a_tg = tg; a_tk = tk;
    @(negedge clk); a_uv = 0;
  endtask

  task automatic upd_b(logic [31:0] br, logic [31:0] tg, logic tk);
    @(negedge clk); b_uv = 1; b_br = br; b_tg = tg; b_tk = tk;
    @(negedge clk); b_uv = 0;
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // ---- instance A: 32 entries, zero-cycle keying, taken-only
    look_a(32'h100, 0, 0, "R1 reset miss / R2");
    upd_a(32'h1000, 32'h2000, 1);
    look_a(32'h0FFC, 1, 32'h2000, "R3 R4 hit at branch-4");
    look_a(32'h1000, 0, 0, "R4 no hit at branch address");
    // R5 collision: lookup and update to same tag in one cycle
    @(negedge clk); a_uv = 1; a_br = 32'h3000; a_tg = 32'h4000; a_tk = 1; a_fa = 32'h2FFC; #1;
    chk("R5 old contents same cycle", {31'd0, a_hit}, 32'd0);
    @(negedge clk); a_uv = 0; #1;
    chk("R5 new value next cycle", a_nf, 32'h4000);
    upd_a(32'h5000, 32'h5100, 0);
    look_a(32'h4FFC, 0, 0, "R6 not-taken miss not allocated");
    upd_a(32'h1000, 32'h6000, 1);
    look_a(32'h0FFC, 1, 32'h6000, "R8 overwrite in place");
    for (int k = 0; k < 30; k++) upd_a(32'h8000 + 4 * k, 32'h9000 + 16 * k, 1);
    look_a(32'h0FFC, 1, 32'h6000, "R10 R8 slot0 kept when full");
    look_a(32'h2FFC, 1, 32'h4000, "R10 slot1 kept when full");
    for (int k = 0; k < 30; k++) look_a(32'h7FFC + 4 * k, 1, 32'h9000 + 16 * k, "R10 sweep 32");
    upd_a(32'hA000, 32'hB000, 1);
    look_a(32'h0FFC, 0, 0, "R9 first victim slot0");
    look_a(32'h9FFC, 1, 32'hB000, "R9 new entry present");
    upd_a(32'hA100, 32'hB100, 1);
    look_a(32'h2FFC, 0, 0, "R9 second victim slot1");
    upd_a(32'h8000, 32'h0, 0);
    look_a(32'h7FFC, 0, 0, "R6 not-taken hit invalidates");
    look_a(32'h8000, 1, 32'h9010, "R6 neighbour kept");
    upd_a(32'hA200, 32'hB200, 1);
    look_a(32'hA1FC, 1, 32'hB200, "R9 free slot reused");
    upd_a(32'hA300, 32'hB300, 1);
    look_a(32'hA1FC, 0, 0, "R9 pointer not moved by free fill");
    look_a(32'h8000, 1, 32'h9010, "R9 slot3 untouched");
    look_a(32'hA2FC, 1, 32'hB300, "R9 replacement present");
    @(negedge clk); a_flush = 1; a_uv = 1; a_br = 32'hC000; a_tg = 32'hD000; a_tk = 1;
    @(negedge clk); a_flush = 0; a_uv = 0;
    look_a(32'h9FFC, 0, 0, "R1 flush clears");
    look_a(32'hBFFC, 0, 0, "R1 update dropped under flush");
    // ---- instance B: 256 entries, branch-address keying, all branches
    look_b(32'h800, 0, 0, "R1 reset miss B");
    upd_b(32'h800, 32'h900, 0);
    look_b(32'h800, 1, 32'h900, "R7 not-taken allocated");
    look_b(32'h7FC, 0, 0, "R4 no hit at branch-4 in normal keying");
    upd_b(32'h800, 32'hA00, 1);
    look_b(32'h800, 1, 32'hA00, "R7 R8 target refreshed");
    for (int k = 0; k < 255; k++) upd_b(32'h10000 + 4 * k, 32'h20000 + 8 * k, k[0]);
    look_b(32'h800, 1, 32'hA00, "R10 slot0 kept 256");
    for (int k = 0; k < 255; k++) look_b(32'h10000 + 4 * k, 1, 32'h20000 + 8 * k, "R10 sweep 256");
    upd_b(32'h30000, 32'h31000, 1);
    look_b(32'h800, 0, 0, "R9 victim slot0 B");
    look_b(32'h30000, 1, 32'h31000, "R9 new entry B");
    upd_b(32'h30004, 32'h31004, 0);
    look_b(32'h10000, 0, 0, "R9 victim slot1 B");
    look_b(32'h10004, 1, 32'h20008, "R9 slot2 kept B");
    @(negedge clk); b_flush = 1;
    @(negedge clk); b_flush = 0;
    look_b(32'h10014, 0, 0, "R1 flush clears B");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule